// File: doc/BRIEF.md
# PCI Address-Phase Command Checker

This block is a passive protocol monitor for a conventional PCI bus. It never drives the bus. On every address phase it captures the four-bit command and the two low address bits. The bus front end also hands it the byte enables of the first data phase, aligned to the same strobe. Afterwards it follows target claim, disconnect and data-phase completion until the transaction ends.

From these observations it judges whether the command and the command-specific meaning of the low address bits were legal. It also remembers whether the previous address phase was a dual-address cycle, so that an illegal pair of them is caught.

Each rule has its own flag bit. A flag sets in the clock after the offending observation and stays set until reset. Full address decoding, configuration space and data contents are outside this block.

Top module: `pci_cmd_checker`

## Requirements
- R1: An address phase carrying a reserved command code (0100, 0101, 1000 or 1001) sets `err_flags[0]`. No other command code sets it.
- R2: An address phase carrying the dual-address code 1101 sets `err_flags[1]` when the previous address phase also carried 1101. A dual-address cycle whose predecessor was any other command, or which is the first address phase after reset, does not set it.
- R3: For the IO codes 0010 and 0011, `err_flags[2]` sets when at least one lane of `lane_en` is enabled and the index of the lowest enabled lane differs from `ad_lo`. An IO address phase with all lanes disabled is accepted.
- R4: For the configuration codes 1010 and 1011 with `ad_lo` equal to 10 or 11, `err_flags[3]` sets if `tgt_sel` is seen at any later clock before the transaction ends. A type 00 or 01 configuration cycle may be claimed freely.
- R5: Memory Write and Invalidate (1111) with `ad_lo` other than 00 sets `err_flags[4]`.
- R6: For the memory codes 0110, 0111, 1100, 1110 and 1111 with `ad_lo` equal to 01 or 11 (reserved orderings), `err_flags[5]` sets when a second completed data phase occurs within the same transaction. The cacheline-wrap ordering 10 and the linear ordering 00 never set it.
- R7: All flags are zero after reset. Once set, a flag stays set until the next reset, and later legal traffic does not clear it.
- R8: A transaction ends when `cyc_busy` is low and no new address phase is present. Claim and data-phase tracking from one transaction does not carry into the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_vld | input | 1 | High for the single clock of an address phase |
| cmd | input | 4 | Bus command code, active-high form |
| ad_lo | input | ADLO_W (2) | Low address bits captured with the address phase |
| lane_en | input | LANES (4) | Active-high byte enables of the first data phase, aligned to `addr_vld` |
| cyc_busy | input | 1 | High while a transaction is in progress |
| tgt_sel | input | 1 | Target has claimed the transaction |
| data_ack | input | 1 | A data phase completes in this clock |
| err_flags | output | 6 | Sticky rule-violation flags, bit positions as in R1 to R6 |

## Verification
The bench sweeps every command code against every value of the low address bits and every byte-enable pattern. It runs each combination with and without a target claim, and with one or two completed data phases. This catches a decoder that misses a reserved code or a memory code. It also catches an IO check that compares against the highest lane instead of the lowest, and one that rejects an all-disabled access.

Separate sequences test dual-address cycles. One pair is back-to-back, and another is split by an ordinary command. A checker that keeps the history bit across unrelated commands would flag the split pair. A checker that forgets it would miss the back-to-back pair.

A sticky run confirms that legal traffic after a violation leaves the earlier flag set. It also confirms that a second violation adds its own bit to the first.

// File: rtl/pci_chk_pkg.sv
package pci_chk_pkg;

   localparam int CMD_W  = 4;
   localparam int NRULE  = 6;

   localparam logic [CMD_W-1:0] C_IO_RD   = 4'b0010;
   localparam logic [CMD_W-1:0] C_IO_WR   = 4'b0011;
   localparam logic [CMD_W-1:0] C_RSV_A   = 4'b0100;
   localparam logic [CMD_W-1:0] C_RSV_B   = 4'b0101;
   localparam logic [CMD_W-1:0] C_MEM_RD  = 4'b0110;
   localparam logic [CMD_W-1:0] C_MEM_WR  = 4'b0111;
   localparam logic [CMD_W-1:0] C_RSV_C   = 4'b1000;
   localparam logic [CMD_W-1:0] C_RSV_D   = 4'b1001;
   localparam logic [CMD_W-1:0] C_CFG_RD  = 4'b1010;
   localparam logic [CMD_W-1:0] C_CFG_WR  = 4'b1011;
   localparam logic [CMD_W-1:0] C_MEM_RDM = 4'b1100;
   localparam logic [CMD_W-1:0] C_DUALADR = 4'b1101;
   localparam logic [CMD_W-1:0] C_MEM_RDL = 4'b1110;
   localparam logic [CMD_W-1:0] C_MEM_WAI = 4'b1111;

   typedef enum int unsigned {
      RULE_RSVD   = 0,
      RULE_DAC2   = 1,
      RULE_IOALN  = 2,
      RULE_CFGTY  = 3,
      RULE_MWI    = 4,
      RULE_ORDER  = 5
   } rule_e;

   typedef struct packed {
      logic rsvd;
      logic dac;
      logic io;
      logic cfg_badtype;
      logic mwi_nonlin;
      logic mem_rsv_ord;
   } cmd_class_t;

endpackage

// File: rtl/pci_cmd_decode.sv
module pci_cmd_decode
   import pci_chk_pkg::*;
#(
   parameter int ADLO_W = 2
) (
   input  logic [CMD_W-1:0]  cmd,
   input  logic [ADLO_W-1:0] ad_lo,
   output cmd_class_t        cls
);

   logic is_mem;

   always_comb begin
      is_mem = (cmd == C_MEM_RD)  || (cmd == C_MEM_WR)  ||
               (cmd == C_MEM_RDM) || (cmd == C_MEM_RDL) ||
               (cmd == C_MEM_WAI);
      cls.rsvd        = (cmd == C_RSV_A) || (cmd == C_RSV_B) ||
                        (cmd == C_RSV_C) || (cmd == C_RSV_D);
      cls.dac         = (cmd == C_DUALADR);
      cls.io          = (cmd == C_IO_RD) || (cmd == C_IO_WR);
      cls.cfg_badtype = ((cmd == C_CFG_RD) || (cmd == C_CFG_WR)) && ad_lo[1];
      cls.mwi_nonlin  = (cmd == C_MEM_WAI) && (ad_lo != '0);
      cls.mem_rsv_ord = is_mem && ad_lo[0];
   end

endmodule

// File: rtl/pci_io_lane_check.sv
module pci_io_lane_check #(
   parameter int LANES  = 4,
   parameter int ADLO_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LANES-1:0]  lane_en,
   input  logic [ADLO_W-1:0] ad_lo,
   output logic              mismatch
);

   logic [ADLO_W-1:0] low_idx;
   logic              any_lane;
   logic [LANES-1:0]  below_mask;

   always_comb begin
      low_idx  = '0;
      any_lane = 1'b0;
      for (int i = LANES - 1; i >= 0; i--) begin
         if (lane_en[i]) begin
            low_idx  = ADLO_W'(i);
            any_lane = 1'b1;
         end
      end
      mismatch = any_lane && (low_idx != ad_lo);
   end

   assign below_mask = (LANES'(1) << ad_lo) - LANES'(1);

   AST_IO_MATCH_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
      ((|lane_en) && !mismatch) |-> (lane_en[ad_lo] && ((lane_en & below_mask) == '0))); // R3

endmodule

// File: rtl/pci_txn_tracker.sv
module pci_txn_tracker (
   input  logic clk,
   input  logic rst_n,
   input  logic addr_vld,
   input  logic cyc_busy,
   input  logic tgt_sel,
   input  logic data_ack,
   input  logic arm_cfg,
   input  logic arm_ord,
   output logic hit_cfg,
   output logic hit_ord
);

   logic cfg_armed;
   logic ord_armed;
   logic first_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_armed  <= 1'b0;
         ord_armed  <= 1'b0;
         first_done <= 1'b0;
      end else if (addr_vld) begin
         cfg_armed  <= arm_cfg;
         ord_armed  <= arm_ord;
         first_done <= 1'b0;
      end else if (!cyc_busy) begin
         cfg_armed  <= 1'b0;
         ord_armed  <= 1'b0;
         first_done <= 1'b0;
      end else if (ord_armed && data_ack) begin
         first_done <= 1'b1;
      end
   end

   assign hit_cfg = cfg_armed && tgt_sel && !addr_vld;
   assign hit_ord = ord_armed && first_done && data_ack && !addr_vld;

   AST_IDLE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
      (!cyc_busy && !addr_vld) |=> (!cfg_armed && !ord_armed && !first_done)); // R8

   AST_SECOND_PHASE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      first_done |-> ord_armed); // R6

endmodule

// File: rtl/pci_cmd_checker.sv
module pci_cmd_checker
   import pci_chk_pkg::*;
#(
   parameter int LANES = 4,
   localparam int ADLO_W = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_vld,
   input  logic [CMD_W-1:0]  cmd,
   input  logic [ADLO_W-1:0] ad_lo,
   input  logic [LANES-1:0]  lane_en,
   input  logic              cyc_busy,
   input  logic              tgt_sel,
   input  logic              data_ack,
   output logic [NRULE-1:0]  err_flags
);

   generate
      if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
         $error("pci_cmd_checker: LANES must be a power of two, at least 2");
      end
   endgenerate

   cmd_class_t       cls;
   logic             io_mism;
   logic             hit_cfg;
   logic             hit_ord;
   logic             prev_dac;
   logic [NRULE-1:0] hit;

   pci_cmd_decode #(.ADLO_W(ADLO_W)) u_dec (
      .cmd   (cmd),
      .ad_lo (ad_lo),
      .cls   (cls)
   );

   pci_io_lane_check #(.LANES(LANES), .ADLO_W(ADLO_W)) u_io (
      .clk      (clk),
      .rst_n    (rst_n),
      .lane_en  (lane_en),
      .ad_lo    (ad_lo),
      .mismatch (io_mism)
   );

   pci_txn_tracker u_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr_vld (addr_vld),
      .cyc_busy (cyc_busy),
      .tgt_sel  (tgt_sel),
      .data_ack (data_ack),
      .arm_cfg  (cls.cfg_badtype),
      .arm_ord  (cls.mem_rsv_ord),
      .hit_cfg  (hit_cfg),
      .hit_ord  (hit_ord)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        prev_dac <= 1'b0;
      else if (addr_vld) prev_dac <= cls.dac;
   end

   always_comb begin
      hit             = '0;
      hit[RULE_RSVD]  = addr_vld && cls.rsvd;
      hit[RULE_DAC2]  = addr_vld && cls.dac && prev_dac;
      hit[RULE_IOALN] = addr_vld && cls.io && io_mism;
      hit[RULE_CFGTY] = hit_cfg;
      hit[RULE_MWI]   = addr_vld && cls.mwi_nonlin;
      hit[RULE_ORDER] = hit_ord;
   end

   generate
      for (genvar g = 0; g < NRULE; g++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      err_flags[g] <= 1'b0;
            else if (hit[g]) err_flags[g] <= 1'b1;
         end

         AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            err_flags[g] |=> err_flags[g]); // R7
      end
   endgenerate

   AST_RSVD_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_vld && cls.rsvd) |=> err_flags[RULE_RSVD]); // R1

   AST_DAC_PAIR_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_vld && cmd == C_DUALADR && prev_dac) |=> err_flags[RULE_DAC2]); // R2

   AST_MWI_LINEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_vld && cmd == C_MEM_WAI && ad_lo != '0) |=> err_flags[RULE_MWI]); // R5

   AST_CFG_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
      hit_cfg |=> err_flags[RULE_CFGTY]); // R4

endmodule

// File: tb/tb_pci_cmd_checker.sv
module tb_pci_cmd_checker;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       addr_vld = 1'b0;
   logic [3:0] cmd = '0;
   logic [1:0] ad_lo = '0;
   logic [3:0] lane_en = '0;
   logic       cyc_busy = 1'b0;
   logic       tgt_sel = 1'b0;
   logic       data_ack = 1'b0;
   logic [5:0] err_flags;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pci_cmd_checker dut (
      .clk(clk), .rst_n(rst_n), .addr_vld(addr_vld), .cmd(cmd), .ad_lo(ad_lo),
      .lane_en(lane_en), .cyc_busy(cyc_busy), .tgt_sel(tgt_sel),
      .data_ack(data_ack), .err_flags(err_flags)
   );

   task automatic check(input string req, input logic [5:0] exp);
      total++;
      if (err_flags !== exp) begin
         bad++;
         $display("FAIL %s: err_flags=%b expected=%b (cmd=%b ad_lo=%b lanes=%b)",
                  req, err_flags, exp, cmd, ad_lo, lane_en);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; addr_vld = 0; cyc_busy = 0; tgt_sel = 0; data_ack = 0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic addr_phase(input logic [3:0] c, input logic [1:0] a, input logic [3:0] l);
      @(negedge clk);
      addr_vld = 1; cyc_busy = 1; cmd = c; ad_lo = a; lane_en = l;
      @(negedge clk);
      addr_vld = 0;
   endtask

   task automatic finish_txn(input bit claim, input int nacks);
      tgt_sel = claim;
      for (int k = 0; k < nacks; k++) begin
         @(negedge clk); data_ack = 1;
         @(negedge clk); data_ack = 0;
      end
      @(negedge clk);
      cyc_busy = 0; tgt_sel = 0;
      @(negedge clk);
   endtask

   function automatic logic [5:0] expect_one(input logic [3:0] c, input logic [1:0] a,
                                             input logic [3:0] l, input bit claim, input int nacks);
      logic [5:0] e = '0;
      int low = -1;
      bit mem;
      for (int i = 3; i >= 0; i--) if (l[i]) low = i;
      e[0] = (c == 4 || c == 5 || c == 8 || c == 9);
      e[2] = (c == 2 || c == 3) && (low >= 0) && (low != int'(a));
      e[3] = (c == 10 || c == 11) && (a >= 2) && claim;
      e[4] = (c == 15) && (a != 0);
      mem  = (c == 6 || c == 7 || c == 12 || c == 14 || c == 15);
      e[5] = mem && (a % 2 == 1) && (nacks >= 2);
      return e;
   endfunction

   initial begin
      do_reset();
      @(negedge clk);
      check("R7 reset", 6'b0);

      // R1 R3 R4 R5 R6: sweep of command, ordering bits, lanes, claim, phases
      for (int c = 0; c < 16; c++)
         for (int a = 0; a < 4; a++)
            for (int l = 0; l < 16; l++)
               for (int v = 0; v < 4; v++) begin
                  if (c == 13) continue;
                  do_reset();
                  addr_phase(4'(c), 2'(a), 4'(l));
                  finish_txn(v[0], 1 + v[1]);
                  check("R1/R3/R4/R5/R6 sweep",
                        expect_one(4'(c), 2'(a), 4'(l), v[0], 1 + v[1]));
               end

      // R2: single dual-address cycle after reset is legal
      do_reset();
      addr_phase(4'hD, 0, 4'hF); addr_phase(4'h6, 0, 4'hF); finish_txn(1, 1);
      check("R2 single dual-address", 6'b0);

      // R2: back-to-back dual-address phases
      do_reset();
      addr_phase(4'hD, 0, 4'hF); addr_phase(4'hD, 0, 4'hF); finish_txn(1, 1);
      check("R2 dual after dual", 6'b000010);

      // R2: split by an ordinary command
      do_reset();
      addr_phase(4'hD, 0, 4'hF); addr_phase(4'h7, 0, 4'hF); finish_txn(1, 1);
      addr_phase(4'hD, 0, 4'hF); addr_phase(4'h6, 0, 4'hF); finish_txn(1, 1);
      check("R2 separated dual", 6'b0);

      // R8: reserved-order read ends, next linear read with two phases is clean
      do_reset();
      addr_phase(4'h6, 1, 4'hF); finish_txn(1, 1);
      addr_phase(4'h6, 0, 4'hF); finish_txn(1, 2);
      check("R8 no carry ordering", 6'b0);

      // R8: bad-type config ends unclaimed, then claim of a memory cycle
      do_reset();
      addr_phase(4'hA, 3, 4'hF); finish_txn(0, 1);
      addr_phase(4'h7, 0, 4'hF); finish_txn(1, 1);
      check("R8 no carry config", 6'b0);

      // R7: sticky flag survives legal traffic and accumulates
      do_reset();
      addr_phase(4'h4, 0, 4'hF); finish_txn(1, 1);
      check("R7 set", 6'b000001);
      addr_phase(4'h6, 0, 4'hF); finish_txn(1, 2);
      check("R7 hold", 6'b000001);
      addr_phase(4'hF, 2, 4'hF); finish_txn(1, 1);
      check("R7 accumulate", 6'b010001);

      done = 1'b1;
   end

   initial begin
      for (int n = 0; n < 190000; n++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule